// File: doc/BRIEF.md
# Playback Byte-Count Transfer Engine

This block drives the playback side of an audio codec's data path. A single format byte names the sample rate, the channel count and the sample encoding. The block decodes that byte and reports the result on its outputs. It also flags rate or encoding codes that cannot be played. While playback is enabled and the format is legal, the block requests bytes from a DMA source. It passes each accepted byte straight on to the output path.

With interrupts enabled, the block counts the bytes it accepts. The limit is a programmable 16-bit block count, scaled up by a shift that depends on the format. On the byte that completes the block, it raises an interrupt and starts the count again from zero. The interrupt stays high until the register interface clears it. Companding expansion and the analog side are outside this block.

Top module: `pb_xfer_engine`

## Requirements
- R1: The rate is taken from the format byte. Bit 0 picks the crystal and bits 3:1 form a rate index. With crystal 0, indices 0..7 give 8000, 16000, 27420, 32000, (none), (none), 48000 and 9000 Hz. With crystal 1 they give 5510, 11025, 18900, 22050, 37800, 44100, 33075 and 6620 Hz. An index with no rate reports 0 Hz and sets the error flag.
- R2: The encoding code comes from bits 7:5 of the format byte. When extended mode is off, only bits 6:5 are used and the top bit reads as 0. Code 0 is unsigned 8-bit, 1 is mu-law, 2 is signed 16-bit little-endian, 3 is A-law and 6 is signed 16-bit big-endian. Codes 4, 5 and 7 set the error flag. Bit 4 of the format byte selects stereo (1) or mono (0).
- R3: The count shift depends on the format. For 8-bit and companded codes it is 0 for mono and 1 for stereo. For the 16-bit codes it is 1 for mono and 2 for stereo.
- R4: The DMA request rises one clock after the enable goes high, provided the format is legal. It falls one clock after the enable goes low or the format becomes illegal.
- R5: Each time the request starts, the transferred-byte count restarts from zero.
- R6: A byte is accepted only in a cycle where the request is high, the format is legal, a byte is offered and the output path is ready. The output carries the byte unchanged, in the same cycle.
- R7: With interrupts enabled, the interrupt rises on the clock that accepts the byte which brings the count to the block count shifted left by the count shift. The count then restarts from zero.
- R8: With interrupts disabled, bytes still flow but are not counted and raise no interrupt.
- R9: A pulse on the interrupt-clear input lowers the interrupt on the next clock. If a block completes in the same cycle, the interrupt stays high.
- R10: With interrupts enabled and a block count of zero, no byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_byte | input | 8 | Rate, channel and encoding selector |
| ext_mode | input | 1 | Widens the encoding field to three bits |
| play_en | input | 1 | Playback enable |
| irq_en | input | 1 | Enables counting and the interrupt |
| base_count | input | 16 | Block count before scaling |
| byte_valid | input | 1 | DMA source offers a byte |
| byte_data | input | 8 | Offered byte |
| out_ready | input | 1 | Output path can take a byte |
| irq_clear | input | 1 | Clears the interrupt |
| dma_req | output | 1 | DMA request |
| byte_ack | output | 1 | Byte accepted this cycle |
| out_valid | output | 1 | Byte presented to the output path |
| out_data | output | 8 | Byte to the output path |
| rate_hz | output | 16 | Decoded sample rate, 0 when the rate is illegal |
| stereo | output | 1 | Two channels |
| fmt_code | output | 3 | Encoding code after masking |
| sample16 | output | 1 | 16-bit linear encoding |
| big_endian | output | 1 | 16-bit big-endian encoding |
| cnt_shift | output | 2 | Count shift |
| fmt_err | output | 1 | Illegal rate or encoding |
| irq | output | 1 | Playback interrupt |

## Verification
The bench aims at the exact byte that closes a block, in mono 8-bit and in stereo 16-bit. A wrong shift or an off-by-one compare moves the interrupt one byte early or late, or by a factor of two or four. It checks that code 5 is legal only while extended mode masks it to mu-law. It also checks that crystal 0 indices 4 and 5 are rejected. A request that does not restart the count fires early after a re-enable. Transfers are tried with the output path stalled, with interrupts off, and with a zero block count. In each case a design that leaks bytes or counts them anyway shows up as a wrong acknowledge or a wrongly timed interrupt.

// File: rtl/pb_pkg.sv
package pb_pkg;

  localparam int RATE_W = 16;

  typedef enum logic [2:0] {
    ENC_U8    = 3'd0,
    ENC_ULAW  = 3'd1,
    ENC_S16LE = 3'd2,
    ENC_ALAW  = 3'd3,
    ENC_RSV4  = 3'd4,
    ENC_ADPCM = 3'd5,
    ENC_S16BE = 3'd6,
    ENC_RSV7  = 3'd7
  } enc_e;

  // sample rate from crystal select and rate index, 0 = not available
  function automatic logic [RATE_W-1:0] rate_of(input logic xtal, input logic [2:0] idx);
    logic [RATE_W-1:0] r;
    if (!xtal) begin
      case (idx)
        3'd0: r = 16'd8000;
        3'd1: r = 16'd16000;
        3'd2: r = 16'd27420;
        3'd3: r = 16'd32000;
        3'd6: r = 16'd48000;
        3'd7: r = 16'd9000;
        default: r = '0;
      endcase
    end else begin
      case (idx)
        3'd0: r = 16'd5510;
        3'd1: r = 16'd11025;
        3'd2: r = 16'd18900;
        3'd3: r = 16'd22050;
        3'd4: r = 16'd37800;
        3'd5: r = 16'd44100;
        3'd6: r = 16'd33075;
        default: r = 16'd6620;
      endcase
    end
    return r;
  endfunction

  function automatic logic [2:0] mask_code(input logic [2:0] raw, input logic ext);
    return ext ? raw : {1'b0, raw[1:0]};
  endfunction

  function automatic logic code_legal(input logic [2:0] code);
    return !(code == ENC_RSV4 || code == ENC_ADPCM || code == ENC_RSV7);
  endfunction

  function automatic logic code_is16(input logic [2:0] code);
    return (code == ENC_S16LE) || (code == ENC_S16BE);
  endfunction

  // bytes-per-frame as a left shift
  function automatic logic [1:0] shift_of(input logic is16, input logic two_ch);
    return {1'b0, is16} + {1'b0, two_ch};
  endfunction

endpackage

// File: rtl/pb_fmt_decode.sv
module pb_fmt_decode
  import pb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        fmt_byte,
  input  logic              ext_mode,
  output logic [RATE_W-1:0] rate_hz,
  output logic              stereo,
  output logic [2:0]        fmt_code,
  output logic              sample16,
  output logic              big_endian,
  output logic [1:0]        cnt_shift,
  output logic              fmt_err
);

  logic rate_bad;
  logic code_bad;

  always_comb begin
    rate_hz    = rate_of(fmt_byte[0], fmt_byte[3:1]);
    rate_bad   = (rate_hz == '0);
    stereo     = fmt_byte[4];
    fmt_code   = mask_code(fmt_byte[7:5], ext_mode);
    code_bad   = !code_legal(fmt_code);
    sample16   = code_is16(fmt_code);
    big_endian = (fmt_code == ENC_S16BE);
    cnt_shift  = shift_of(sample16, stereo);
    fmt_err    = rate_bad | code_bad;
  end

  assert_shift_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_shift <= 2'd2) && (sample16 -> cnt_shift != 2'd0));

  assert_masked_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> !fmt_code[2]);

endmodule

// File: rtl/pb_req_ctrl.sv
module pb_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic play_en,
  input  logic fmt_err,
  output logic dma_req,
  output logic start
);

  logic run_q;
  logic run_d;

  assign run_d   = play_en & ~fmt_err;
  assign start   = run_d & ~run_q;
  assign dma_req = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!play_en || fmt_err) |=> !dma_req);

  assert_req_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> dma_req);

endmodule

// File: rtl/pb_byte_counter.sv
module pb_byte_counter #(
  parameter int BASE_W = 16,
  localparam int CNT_W = BASE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              accept,
  input  logic              irq_en,
  input  logic [BASE_W-1:0] base_count,
  input  logic [1:0]        cnt_shift,
  input  logic              irq_clear,
  output logic              block_hit,
  output logic              irq
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] cnt_inc;

  assign thr       = {2'b00, base_count} << cnt_shift;
  assign cnt_inc   = cnt_q + 1'b1;
  assign block_hit = accept & irq_en & (cnt_inc >= thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (accept && irq_en) begin
      cnt_q <= block_hit ? '0 : cnt_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq <= 1'b0;
    else if (block_hit) irq <= 1'b1;
    else if (irq_clear) irq <= 1'b0;
  end

  assert_irq_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    block_hit |=> irq && (cnt_q == '0));

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !block_hit) |=> !irq);

  assert_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !start) |=> $stable(cnt_q));

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(block_hit));

endmodule

// File: rtl/pb_xfer_engine.sv
module pb_xfer_engine
  import pb_pkg::*;
#(
  parameter int BASE_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        fmt_byte,
  input  logic              ext_mode,
  input  logic              play_en,
  input  logic              irq_en,
  input  logic [BASE_W-1:0] base_count,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              out_ready,
  input  logic              irq_clear,
  output logic              dma_req,
  output logic              byte_ack,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [RATE_W-1:0] rate_hz,
  output logic              stereo,
  output logic [2:0]        fmt_code,
  output logic              sample16,
  output logic              big_endian,
  output logic [1:0]        cnt_shift,
  output logic              fmt_err,
  output logic              irq
);

  logic start;
  logic zero_block;
  logic pass_ok;
  logic block_hit;

  pb_fmt_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_byte   (fmt_byte),
    .ext_mode   (ext_mode),
    .rate_hz    (rate_hz),
    .stereo     (stereo),
    .fmt_code   (fmt_code),
    .sample16   (sample16),
    .big_endian (big_endian),
    .cnt_shift  (cnt_shift),
    .fmt_err    (fmt_err)
  );

  pb_req_ctrl u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .play_en (play_en),
    .fmt_err (fmt_err),
    .dma_req (dma_req),
    .start   (start)
  );

  // a zero block with counting on admits nothing
  assign zero_block = irq_en & (base_count == '0);
  assign pass_ok    = dma_req & ~fmt_err & ~zero_block;
  assign out_valid  = pass_ok & byte_valid;
  assign out_data   = byte_data;
  assign byte_ack   = out_valid & out_ready;

  pb_byte_counter #(.BASE_W(BASE_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .accept     (byte_ack),
    .irq_en     (irq_en),
    .base_count (base_count),
    .cnt_shift  (cnt_shift),
    .irq_clear  (irq_clear),
    .block_hit  (block_hit),
    .irq        (irq)
  );

  assert_ack_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ack |-> (dma_req && out_ready && byte_valid && !fmt_err));

  assert_zero_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && base_count == '0) |-> !byte_ack);

  assert_hit_needs_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    block_hit |-> byte_ack);

endmodule

// File: tb/test_pb_xfer_engine.sv
module test_pb_xfer_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  fmt_byte;
  logic        ext_mode, play_en, irq_en;
  logic [15:0] base_count;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        out_ready, irq_clear;
  logic        dma_req, byte_ack, out_valid;
  logic [7:0]  out_data;
  logic [15:0] rate_hz;
  logic        stereo;
  logic [2:0]  fmt_code;
  logic        sample16, big_endian;
  logic [1:0]  cnt_shift;
  logic        fmt_err, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pb_xfer_engine i_pb_xfer_engine (
    .clk(clk), .rst_n(rst_n), .fmt_byte(fmt_byte), .ext_mode(ext_mode),
    .play_en(play_en), .irq_en(irq_en), .base_count(base_count),
    .byte_valid(byte_valid), .byte_data(byte_data), .out_ready(out_ready),
    .irq_clear(irq_clear), .dma_req(dma_req), .byte_ack(byte_ack),
    .out_valid(out_valid), .out_data(out_data), .rate_hz(rate_hz),
    .stereo(stereo), .fmt_code(fmt_code), .sample16(sample16),
    .big_endian(big_endian), .cnt_shift(cnt_shift), .fmt_err(fmt_err), .irq(irq)
  );

  function automatic int exp_rate(input int xtal, input int idx);
    int t0 [8] = '{8000, 16000, 27420, 32000, 0, 0, 48000, 9000};
    int t1 [8] = '{5510, 11025, 18900, 22050, 37800, 44100, 33075, 6620};
    return xtal ? t1[idx] : t0[idx];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  // offer one byte; reports ack in this cycle and irq after the edge
  task automatic send(input logic [7:0] d, output bit acked, output bit irq_after);
    byte_valid = 1'b1;
    byte_data  = d;
    #1;
    acked = byte_ack;
    @(posedge clk);
    #1;
    irq_after = irq;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic enable_play(input logic [7:0] f, input logic [15:0] bc);
    fmt_byte = f; base_count = bc;
    play_en = 1'b0; tick;
    play_en = 1'b1; tick;
  endtask

  task automatic clear_irq;
    irq_clear = 1'b1; tick; irq_clear = 1'b0;
  endtask

  task automatic t_reset;
    chk("R4", "dma_req after reset", dma_req, 0);
    chk("R7", "irq after reset", irq, 0);
    chk("R6", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_rates;
    for (int x = 0; x < 2; x++)
      for (int i = 0; i < 8; i++) begin
        fmt_byte = 8'(x | (i << 1)); ext_mode = 1'b0; #1;
        chk("R1", $sformatf("rate x%0d i%0d", x, i), rate_hz, exp_rate(x, i));
        chk("R1", "rate err flag", fmt_err, exp_rate(x, i) == 0);
      end
  endtask

  task automatic t_codes;
    for (int e = 0; e < 2; e++)
      for (int c = 0; c < 8; c++) begin
        int m;
        m = e ? c : (c & 3);
        ext_mode = e[0];
        fmt_byte = 8'((c << 5) | 8'h10); #1;
        chk("R2", $sformatf("code e%0d c%0d", e, c), fmt_code, m);
        chk("R2", "code err flag", fmt_err, (m == 4 || m == 5 || m == 7));
        chk("R2", "stereo bit", stereo, 1);
        chk("R2", "big endian", big_endian, m == 6);
        chk("R3", "count shift stereo", cnt_shift, (m == 2 || m == 6) ? 2 : 1);
      end
    ext_mode = 1'b0;
    fmt_byte = 8'h40; #1;
    chk("R3", "count shift mono 16", cnt_shift, 1);
    fmt_byte = 8'h20; #1;
    chk("R3", "count shift mono ulaw", cnt_shift, 0);
  endtask

  task automatic t_enable;
    fmt_byte = 8'h00; play_en = 1'b1; #1;
    chk("R4", "req before edge", dma_req, 0);
    tick;
    chk("R4", "req after enable", dma_req, 1);
    play_en = 1'b0; tick;
    chk("R4", "req after disable", dma_req, 0);
    play_en = 1'b1; tick;
    fmt_byte = 8'h08; #1;
    chk("R6", "no pass on bad format", out_valid, 0);
    tick;
    chk("R4", "req after bad rate", dma_req, 0);
    fmt_byte = 8'h00; tick;
    chk("R4", "req back after good rate", dma_req, 1);
  endtask

  task automatic t_mono_block;
    bit a, q;
    irq_en = 1'b1; out_ready = 1'b1;
    enable_play(8'h00, 16'd3);
    send(8'hA5, a, q);
    chk("R6", "ack byte 1", a, 1);
    send(8'h5A, a, q);
    chk("R7", "irq after 2 of 3", q, 0);
    send(8'h33, a, q);
    chk("R7", "irq after 3 of 3", q, 1);
    clear_irq;
    chk("R9", "irq after clear", irq, 0);
    send(8'h01, a, q);
    chk("R7", "restart after block", q, 0);
    send(8'h01, a, q); send(8'h01, a, q);
    chk("R7", "second block", q, 1);
    clear_irq;
  endtask

  task automatic t_stereo16;
    bit a, q;
    enable_play(8'h50, 16'd2);
    for (int k = 0; k < 7; k++) send(8'(k), a, q);
    chk("R7", "stereo16 irq after 7 of 8", q, 0);
    send(8'h07, a, q);
    chk("R7", "stereo16 irq after 8", q, 1);
    clear_irq;
  endtask

  task automatic t_passthru_stall;
    bit a, q;
    enable_play(8'h00, 16'd2);
    byte_valid = 1'b1; byte_data = 8'hC3; #1;
    chk("R6", "out_data passes", out_data, 8'hC3);
    out_ready = 1'b0; #1;
    chk("R6", "no ack when stalled", byte_ack, 0);
    tick; tick;
    byte_valid = 1'b0; out_ready = 1'b1;
    send(8'h11, a, q);
    chk("R6", "stall did not count", q, 0);
    send(8'h22, a, q);
    chk("R7", "block after stall", q, 1);
    clear_irq;
  endtask

  task automatic t_no_irq_en;
    bit a, q;
    enable_play(8'h00, 16'd2);
    irq_en = 1'b0;
    send(8'h01, a, q);
    chk("R8", "ack with irq off", a, 1);
    for (int k = 0; k < 4; k++) send(8'h02, a, q);
    chk("R8", "no irq while off", irq, 0);
    irq_en = 1'b1;
    send(8'h03, a, q);
    chk("R8", "uncounted bytes", q, 0);
    send(8'h03, a, q);
    chk("R8", "count resumes", q, 1);
    clear_irq;
  endtask

  task automatic t_restart;
    bit a, q;
    enable_play(8'h00, 16'd3);
    send(8'h01, a, q); send(8'h01, a, q);
    enable_play(8'h00, 16'd3);
    send(8'h01, a, q); send(8'h01, a, q);
    chk("R5", "count cleared on start", q, 0);
    send(8'h01, a, q);
    chk("R5", "full block after start", q, 1);
    // set and clear in one cycle: set wins
    irq_clear = 1'b1;
    send(8'h01, a, q); send(8'h01, a, q); send(8'h01, a, q);
    chk("R9", "hit beats clear", q, 1);
    irq_clear = 1'b0;
    clear_irq;
  endtask

  task automatic t_zero_block;
    bit a, q;
    enable_play(8'h00, 16'd0);
    send(8'h01, a, q);
    chk("R10", "no ack on zero block", a, 0);
    irq_en = 1'b0;
    send(8'h01, a, q);
    chk("R10", "ack with counting off", a, 1);
    irq_en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; fmt_byte = 8'h00; ext_mode = 1'b0; play_en = 1'b0;
    irq_en = 1'b0; base_count = 16'd0; byte_valid = 1'b0; byte_data = 8'h00;
    out_ready = 1'b1; irq_clear = 1'b0;
    repeat (3) tick;
    rst_n = 1'b1; tick;
    t_reset;
    t_rates;
    t_codes;
    t_enable;
    t_mono_block;
    t_stereo16;
    t_passthru_stall;
    t_no_irq_en;
    t_restart;
    t_zero_block;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule